// File: doc/BRIEF.md
# Last Branch Record Ring Buffer

This block keeps a short history of the branches a core has most recently taken. Each retired taken branch arrives as a source address, a target address and a mispredict bit. While recording is on, the block writes them into a small circular store and moves a top-of-stack pointer forward by one. Software finds the newest record through the pointer and walks backwards through older ones. The index of the i-th most recent record is (top - i) masked with depth - 1.

A performance-monitor interrupt input can freeze the history. While the freeze option is on, an interrupt pulse stops all further recording, so the handler reads a history that matches the moment of the overflow. A 64-bit register port with word addresses gives software:
- a control word,
- a read-only pointer register,
- a read-only capabilities word that reports the record format,
- the indexed source and target entries.

Software clears history between contexts by writing zeros to the entries. The record format is fixed when the block is built. Format 0 packs both addresses into one 64-bit source entry. Formats 1 and 2 store full addresses. Format 3 puts the mispredict bit on top of the source address.

Top module: `lbr_recorder`

## Requirements
- R1: After reset the control word, the pointer and every source and target entry read as zero.
- R2: Recording happens when a branch is valid, control bit 0 (record enable) is 1, and the frozen status is 0. On such a cycle the pointer (word address 1) advances by one modulo DEPTH, and the record is written at the new pointer value. Source entries sit at word address 0x10+i and target entries at 0x20+i.
- R3: While record enable is 0, valid branches change neither the pointer nor any entry.
- R4: Control bit 11 is the freeze enable and control bit 16 is the frozen status. An interrupt pulse with freeze enable at 1 sets the frozen status, and from the next cycle no branch is recorded. An interrupt with freeze enable at 0 has no effect.
- R5: Writing the control word with bit 16 at 0 clears the frozen status. Writing it with bit 16 at 1 never sets the status. After the status clears, recording resumes.
- R6: In format 3, source entry bit 63 holds the mispredict bit and bits 62:0 hold source address bits 62:0. Sign-extending bit 62 restores a canonical address.
- R7: The capabilities word (word address 2) reports the format code in bits 4:0: 0 packed 32-bit, 1 linear, 2 effective, 3 effective with flags. All other bits are zero.
- R8: Writes to the pointer and capabilities addresses are ignored.
- R9: Software can write any source and target entry. Writing zeros clears the history. Entry indices at or above DEPTH read as zero and ignore writes.
- R10: When a recorded branch and a register write hit the same entry in one cycle, the branch record is stored.
- R11: Reading source entries at (pointer - i) mod DEPTH for i = 0..DEPTH-1 returns the last DEPTH recorded branches, newest first.
- R12: In format 0, a source entry holds the target address bits 31:0 in bits 63:32 and the source address bits 31:0 in bits 31:0. Target entries read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| br_valid | input | 1 | A taken branch retires this cycle |
| br_from | input | 64 | Branch source address |
| br_to | input | 64 | Branch target address |
| br_mispred | input | 1 | Branch was mispredicted |
| pmi | input | 1 | Performance-monitor interrupt pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |

## Verification
Every state change (a recorded branch, a register write, a freeze) appears on the port one clock edge after the cycle that carries the stimulus. Register reads are combinational from the stored state. The bench drives inputs on the falling edge. Its behavioural model updates on the rising edge, and the read data is compared a quarter period later, so each result is checked in the first cycle in which it is due. Directed reads follow the same rule: a read is driven on the falling edge after the stimulus cycle and sampled shortly after.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned DW     = 64;

  localparam logic [REG_AW-1:0] A_CTRL = 6'h00;
  localparam logic [REG_AW-1:0] A_TOS  = 6'h01;
  localparam logic [REG_AW-1:0] A_CAPS = 6'h02;
  localparam logic [1:0]        BANK_FROM = 2'd1;
  localparam logic [1:0]        BANK_TO   = 2'd2;

  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_FZ_EN  = 11;
  localparam int unsigned CB_FROZEN = 16;

  typedef enum logic [4:0] {
    FMT_PACK32  = 5'd0,
    FMT_LINEAR  = 5'd1,
    FMT_EFFECT  = 5'd2,
    FMT_EFFFLAG = 5'd3
  } rec_fmt_e;
endpackage

// File: rtl/lbr_rst_sync.sv
module lbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import lbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          ctrl_we,
  input  logic [DW-1:0] wdata,
  input  logic          pmi,
  input  logic          br_valid,
  output logic          en,
  output logic          fz_en,
  output logic          frozen,
  output logic          rec_go
);
  logic en_q, fz_en_q, frozen_q;
  logic en_d, fz_en_d, frozen_d;
  logic ce;

  always_comb begin
    en_d     = en_q;
    fz_en_d  = fz_en_q;
    frozen_d = frozen_q;
    if (ctrl_we) begin
      en_d     = wdata[CB_EN];
      fz_en_d  = wdata[CB_FZ_EN];
      frozen_d = frozen_q & wdata[CB_FROZEN];
    end
    if (pmi && fz_en_q) frozen_d = 1'b1;
  end

  assign ce = ctrl_we | pmi;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      fz_en_q  <= 1'b0;
      frozen_q <= 1'b0;
    end else if (ce) begin
      en_q     <= en_d;
      fz_en_q  <= fz_en_d;
      frozen_q <= frozen_d;
    end
  end

  assign en     = en_q;
  assign fz_en  = fz_en_q;
  assign frozen = frozen_q;
  assign rec_go = br_valid & en_q & ~frozen_q;

  a_r4_freeze_sets: assert property (@(posedge clk) disable iff (!rst_ni)
    (pmi && fz_en) |=> frozen);
  a_r5_never_set_by_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (!frozen && !(pmi && fz_en)) |=> !frozen);
  a_r4_frozen_blocks: assert property (@(posedge clk) disable iff (!rst_ni)
    frozen |-> !rec_go);
endmodule

// File: rtl/lbr_ring.sv
module lbr_ring
  import lbr_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned FORMAT = 3,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             rec_go,
  input  logic [DW-1:0]    br_from,
  input  logic [DW-1:0]    br_to,
  input  logic             br_mispred,
  input  logic             we_from,
  input  logic             we_to,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] tos,
  output logic [DW-1:0]    rd_from,
  output logic [DW-1:0]    rd_to
);
  logic [IDX_W-1:0] tos_q, tos_d;
  logic [DW-1:0]    rec_from;
  logic [DW-1:0]    from_q [DEPTH];

  always_comb begin
    case (FORMAT)
      0:       rec_from = {br_to[31:0], br_from[31:0]};
      3:       rec_from = {br_mispred, br_from[DW-2:0]};
      default: rec_from = br_from;
    endcase
  end

  always_comb tos_d = rec_go ? tos_q + IDX_W'(1) : tos_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     tos_q <= '0;
    else if (rec_go) tos_q <= tos_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_from
    logic          hit_rec, hit_wr;
    logic [DW-1:0] d;
    always_comb begin
      hit_rec = rec_go && (tos_d == IDX_W'(g));
      hit_wr  = we_from && (wr_idx == IDX_W'(g));
      d       = hit_rec ? rec_from : wdata;
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)                from_q[g] <= '0;
      else if (hit_rec || hit_wr) from_q[g] <= d;
    end
  end

  assign rd_from = from_q[rd_idx];
  assign tos     = tos_q;

  if (FORMAT != 0) begin : g_to
    logic [DW-1:0] to_q [DEPTH];
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic          hit_rec, hit_wr;
      logic [DW-1:0] d;
      always_comb begin
        hit_rec = rec_go && (tos_d == IDX_W'(g));
        hit_wr  = we_to && (wr_idx == IDX_W'(g));
        d       = hit_rec ? br_to : wdata;
      end
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)                to_q[g] <= '0;
        else if (hit_rec || hit_wr) to_q[g] <= d;
      end
    end
    assign rd_to = to_q[rd_idx];
  end else begin : g_no_to
    assign rd_to = '0;
  end

  a_r2_tos_step: assert property (@(posedge clk) disable iff (!rst_ni)
    rec_go |=> tos_q == $past(tos_q) + IDX_W'(1));
  a_r3_tos_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !rec_go |=> $stable(tos_q));
  a_r10_branch_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    rec_go |=> from_q[tos_q] == $past(rec_from));
  if (FORMAT == 3) begin : g_chk_flag
    a_r6_flag_bit: assert property (@(posedge clk) disable iff (!rst_ni)
      rec_go |=> from_q[tos_q][DW-1] == $past(br_mispred));
  end
  if (FORMAT == 0) begin : g_chk_pack
    a_r12_packed: assert property (@(posedge clk) disable iff (!rst_ni)
      rec_go |=> from_q[tos_q][63:32] == $past(br_to[31:0]));
  end
endmodule

// File: rtl/lbr_recorder.sv
module lbr_recorder
  import lbr_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned FORMAT = 3,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [63:0]   br_from,
  input  logic [63:0]   br_to,
  input  logic          br_mispred,
  input  logic          pmi,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata
);
  localparam logic [DW-1:0] CAPS_WORD = DW'(FORMAT[4:0]);

  logic             rst_ni;
  logic             en, fz_en, frozen, rec_go;
  logic             sel_ctrl, sel_from, sel_to, idx_ok;
  logic [IDX_W-1:0] idx, tos;
  logic [DW-1:0]    rd_from, rd_to;

  lbr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  always_comb begin
    idx      = reg_addr[IDX_W-1:0];
    idx_ok   = ({1'b0, reg_addr[3:0]} < 5'(DEPTH));
    sel_ctrl = (reg_addr == A_CTRL);
    sel_from = (reg_addr[5:4] == BANK_FROM) && idx_ok;
    sel_to   = (reg_addr[5:4] == BANK_TO) && idx_ok;
  end

  lbr_ctrl u_ctrl (
    .clk(clk), .rst_ni(rst_ni),
    .ctrl_we(reg_we && sel_ctrl), .wdata(reg_wdata),
    .pmi(pmi), .br_valid(br_valid),
    .en(en), .fz_en(fz_en), .frozen(frozen), .rec_go(rec_go)
  );

  lbr_ring #(.DEPTH(DEPTH), .FORMAT(FORMAT)) u_ring (
    .clk(clk), .rst_ni(rst_ni), .rec_go(rec_go),
    .br_from(br_from), .br_to(br_to), .br_mispred(br_mispred),
    .we_from(reg_we && sel_from), .we_to(reg_we && sel_to),
    .wr_idx(idx), .wdata(reg_wdata), .rd_idx(idx),
    .tos(tos), .rd_from(rd_from), .rd_to(rd_to)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl) begin
      reg_rdata[CB_EN]     = en;
      reg_rdata[CB_FZ_EN]  = fz_en;
      reg_rdata[CB_FROZEN] = frozen;
    end else if (reg_addr == A_TOS) begin
      reg_rdata = DW'(tos);
    end else if (reg_addr == A_CAPS) begin
      reg_rdata = CAPS_WORD;
    end else if (sel_from) begin
      reg_rdata = rd_from;
    end else if (sel_to) begin
      reg_rdata = rd_to;
    end
  end

  a_r8_ro_tos: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_we && reg_addr == A_TOS && !rec_go) |=> $stable(tos));
  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |-> !rec_go);
endmodule

// File: tb/lbr_recorder_test.sv
module lbr_recorder_test;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        br_valid = 0, br_mispred = 0, pmi = 0, reg_we = 0;
  logic [63:0] br_from = 0, br_to = 0, reg_wdata = 0;
  logic [5:0]  reg_addr = 0;
  logic [63:0] rd, rd_pk;
  int total = 0, bad = 0;
  bit live = 0;

  always #(PERIOD/2) clk = ~clk;

  lbr_recorder #(.DEPTH(8), .FORMAT(3)) uut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
    .br_mispred(br_mispred), .pmi(pmi), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd));
  lbr_recorder #(.DEPTH(4), .FORMAT(0)) uut_pk (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
    .br_mispred(br_mispred), .pmi(pmi), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_pk));

  // behavioural model: index 0 = depth 8 format 3, index 1 = depth 4 format 0
  logic [63:0] mf [2][16];
  logic [63:0] mt [2][16];
  int          mtos [2];
  bit          men [2], mfzen [2], mfz [2];
  int          dep [2] = '{8, 4};
  int          fmt [2] = '{3, 0};

  task automatic mreset();
    for (int k = 0; k < 2; k++) begin
      mtos[k] = 0; men[k] = 0; mfzen[k] = 0; mfz[k] = 0;
      for (int i = 0; i < 16; i++) begin mf[k][i] = 0; mt[k][i] = 0; end
    end
  endtask

  task automatic mstep(int k);
    bit rec = br_valid && men[k] && !mfz[k];
    bit ofz = mfzen[k];
    int idx = int'(reg_addr[3:0]);
    int nt  = (mtos[k] + 1) % dep[k];
    if (reg_we) begin
      if (reg_addr == 0) begin
        men[k] = reg_wdata[0]; mfzen[k] = reg_wdata[11];
        mfz[k] = mfz[k] & reg_wdata[16];
      end
      if (reg_addr[5:4] == 1 && idx < dep[k]) mf[k][idx] = reg_wdata;
      if (reg_addr[5:4] == 2 && idx < dep[k] && fmt[k] != 0) mt[k][idx] = reg_wdata;
    end
    if (pmi && ofz) mfz[k] = 1;
    if (rec) begin
      mtos[k] = nt;
      if (fmt[k] == 0)      mf[k][nt] = {br_to[31:0], br_from[31:0]};
      else if (fmt[k] == 3) mf[k][nt] = {br_mispred, br_from[62:0]};
      else                  mf[k][nt] = br_from;
      if (fmt[k] != 0) mt[k][nt] = br_to;
    end
  endtask

  function automatic logic [63:0] mread(int k, logic [5:0] a);
    int idx = int'(a[3:0]);
    if (a == 0) return {47'b0, mfz[k], 4'b0, mfzen[k], 10'b0, men[k]};
    if (a == 1) return 64'(mtos[k]);
    if (a == 2) return 64'(fmt[k]);
    if (a[5:4] == 1 && idx < dep[k]) return mf[k][idx];
    if (a[5:4] == 2 && idx < dep[k] && fmt[k] != 0) return mt[k][idx];
    return 0;
  endfunction

  function automatic string tag(logic [5:0] a);
    if (a == 0) return "R4";
    if (a == 2) return "R7";
    return "R2";
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) mreset();
    else begin mstep(0); mstep(1); end
  end

  always @(posedge clk) begin
    #(PERIOD/4);
    if (live) begin
      chk(tag(reg_addr), rd, mread(0, reg_addr));
      chk(tag(reg_addr), rd_pk, mread(1, reg_addr));
    end
  end

  task automatic rdchk(int k, logic [5:0] a, logic [63:0] exp, string req);
    @(negedge clk);
    reg_addr = a; reg_we = 0; br_valid = 0; pmi = 0;
    #1;
    chk(req, (k == 0) ? rd : rd_pk, exp);
  endtask

  task automatic wr(logic [5:0] a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic br(logic [63:0] f, logic [63:0] t, logic m);
    @(negedge clk);
    br_valid = 1; br_from = f; br_to = t; br_mispred = m;
    @(negedge clk);
    br_valid = 0;
  endtask

  task automatic pulse_pmi();
    @(negedge clk); pmi = 1;
    @(negedge clk); pmi = 0;
  endtask

  initial begin
    #(PERIOD*100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;
    // R1 reset state
    rdchk(0, 6'h00, 0, "R1");
    rdchk(0, 6'h01, 0, "R1");
    rdchk(0, 6'h13, 0, "R1");
    rdchk(0, 6'h25, 0, "R1");
    // R7 capabilities
    rdchk(0, 6'h02, 64'd3, "R7");
    rdchk(1, 6'h02, 64'd0, "R7");
    // R8 read-only registers
    wr(6'h01, 64'd5);
    wr(6'h02, 64'h1f);
    rdchk(0, 6'h01, 0, "R8");
    rdchk(0, 6'h02, 64'd3, "R8");
    // R2/R6/R12 first records
    wr(6'h00, 64'h801);
    br(64'h1000, 64'h2000, 1);
    rdchk(0, 6'h01, 1, "R2");
    rdchk(0, 6'h11, 64'h8000_0000_0000_1000, "R6");
    rdchk(0, 6'h21, 64'h2000, "R2");
    rdchk(1, 6'h11, 64'h0000_2000_0000_1000, "R12");
    rdchk(1, 6'h21, 0, "R12");
    br(64'hFFFF_FFFF_FFFF_F000, 64'h3000, 0);
    rdchk(0, 6'h12, 64'h7FFF_FFFF_FFFF_F000, "R6");
    r = rd;
    chk("R6", {r[62], r[62:0]}, 64'hFFFF_FFFF_FFFF_F000);
    for (int k = 0; k < 9; k++) br(64'h100 + 64'(k), 64'h200 + 64'(k), 0);
    rdchk(0, 6'h01, 3, "R2");
    rdchk(1, 6'h01, 3, "R2");
    // R11 newest-first walk
    for (int i = 0; i < 8; i++)
      rdchk(0, 6'h10 + 6'((3 - i) & 7), 64'h108 - 64'(i), "R11");
    for (int i = 0; i < 4; i++)
      rdchk(1, 6'h10 + 6'((3 - i) & 3), {32'h208 - 32'(i), 32'h108 - 32'(i)}, "R11");
    // R3 disabled
    wr(6'h00, 64'h800);
    br(64'h5000, 64'h5100, 1);
    rdchk(0, 6'h01, 3, "R3");
    rdchk(0, 6'h14, 64'h101, "R3");
    // R4 freeze
    wr(6'h00, 64'h801);
    pulse_pmi();
    rdchk(0, 6'h00, 64'h10801, "R4");
    br(64'h5200, 64'h5300, 0);
    rdchk(0, 6'h01, 3, "R4");
    // R5 clear frozen
    wr(6'h00, 64'h10801);
    rdchk(0, 6'h00, 64'h10801, "R5");
    wr(6'h00, 64'h801);
    rdchk(0, 6'h00, 64'h801, "R5");
    br(64'h6000, 64'h6100, 0);
    rdchk(0, 6'h01, 4, "R5");
    wr(6'h00, 64'h10801);
    rdchk(0, 6'h00, 64'h801, "R5");
    // R4 no freeze without enable
    wr(6'h00, 64'h1);
    pulse_pmi();
    rdchk(0, 6'h00, 64'h1, "R4");
    br(64'h6200, 64'h6300, 0);
    rdchk(0, 6'h01, 5, "R4");
    // R10 branch wins over same-entry write
    @(negedge clk);
    reg_we = 1; reg_addr = 6'h16; reg_wdata = 64'hDEAD;
    br_valid = 1; br_from = 64'h7000; br_to = 64'h7100; br_mispred = 0;
    @(negedge clk);
    reg_we = 0; br_valid = 0;
    rdchk(0, 6'h16, 64'h7000, "R10");
    rdchk(1, 6'h12, 64'h0000_7100_0000_7000, "R10");
    // R9 clear history
    for (int i = 0; i < 8; i++) begin
      wr(6'h10 + 6'(i), 0);
      wr(6'h20 + 6'(i), 0);
    end
    rdchk(0, 6'h16, 0, "R9");
    rdchk(0, 6'h26, 0, "R9");
    rdchk(1, 6'h12, 0, "R9");
    wr(6'h1C, 64'h55);
    rdchk(1, 6'h1C, 0, "R9");
    rdchk(0, 6'h1C, 0, "R9");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule